// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This block shifts a destination operand by a count and fills the positions it vacates with bits drawn from a second source operand. The fill bits come from the end of the source opposite the shift. In a left shift, the top bits of the source enter the bottom of the destination, most significant source bit first. In a right shift, the bottom bits of the source enter the top of the destination, least significant source bit first. Internally the two operands are joined into one double-width word, which is barrel-shifted. The operation window is then taken from that word.

A caller presents both operands, a count, a direction and an operand size, together with a valid strobe. One clock later the block returns the registered result, a carry and an output strobe. The carry holds the last bit pushed out of the destination. The source operand only supplies fill bits and is never written back. Operands can be 16 or 32 bits wide. In 16-bit mode only the low halves of the inputs take part.

Top module: `dbl_funnel_shifter`

## Requirements
- R1: While reset (`rst_ni` low) is applied, and afterwards until the first accepted operation, `valid_o`, `result_o` and `carry_o` are all zero.
- R2: `valid_o` rises exactly one cycle after `valid_i` is sampled high. When `valid_i` is sampled low, `result_o` and `carry_o` keep their values and `valid_o` is low in the next cycle.
- R3: With `dir_i`=0 (left) and `size_i`=1 (32 bits), a count n from 1 to 31 gives `result_o` = (dst << n) | (src >> (32-n)), truncated to 32 bits.
- R4: With `dir_i`=1 (right) and `size_i`=1, a count n from 1 to 31 gives `result_o` = (dst >> n) | (src << (32-n)), truncated to 32 bits.
- R5: For a left shift by a nonzero count n at width W, `carry_o` equals dst bit W-n.
- R6: For a right shift by a nonzero count n, `carry_o` equals dst bit n-1.
- R7: A count of zero returns the destination, in 16-bit mode zero-extended from its low half. `carry_o` keeps the value it had before that operation.
- R8: With `size_i`=0 (16 bits), only bits 15:0 of `dst_i` and `src_i` are used, and `result_o[31:16]` is zero. Counts from 1 to 16 follow R3 to R6 with a width of 16, so a count of 16 returns the source's low half. For counts of 17 to 31, `result_o[15:0]` and `carry_o` are undefined.
- R9: The 5-bit count selects shift amounts of 0 to 31 directly, with no saturation. A count of 31 moves 31 source bits into the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| dir_i | input | 1 | 0 = shift left, 1 = shift right |
| size_i | input | 1 | 0 = 16-bit operands, 1 = 32-bit operands |
| count_i | input | 5 | Shift count |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Fill-source operand |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| result_o | output | 32 | Shifted destination |
| carry_o | output | 1 | Last bit shifted out of the destination |

## Verification
Two functions can fall in the same cycle: the carry produced by a shifting operation, and the carry hold of a zero-count operation issued immediately behind it. The bench provokes this with back-to-back strobes. The first operation shifts out a known carry, and a zero-count operation follows in the very next cycle, in both directions and with the held carry at both 0 and 1. On the second strobe it judges that the result is the new destination while the carry is still the one the first operation produced.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
   typedef enum logic {
      DIR_LEFT  = 1'b0,
      DIR_RIGHT = 1'b1
   } dfs_dir_e;

   typedef enum logic {
      SIZE_HALF = 1'b0,
      SIZE_FULL = 1'b1
   } dfs_size_e;
endpackage

// File: rtl/dfs_pack.sv
// Builds the double-width funnel word. Left: {guard, hi, lo}, and the window
// sits below the guard bit. Right: {hi, lo, guard}, and the window sits above it.
module dfs_pack
   import dfs_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int HALF_W = DATA_W / 2,
   localparam int WORD_W = 2 * DATA_W + 1
) (
   input  logic              dir_i,
   input  logic              size_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   output logic [WORD_W-1:0] word_o
);
   logic [DATA_W-1:0] hi, lo;
   logic              left;

   assign left = (dir_i == DIR_LEFT);

   always_comb begin
      if (size_i == SIZE_FULL) begin
         hi = left ? dst_i : src_i;
         lo = left ? src_i : dst_i;
      end else if (left) begin
         hi = {dst_i[HALF_W-1:0], src_i[HALF_W-1:0]};
         lo = '0;
      end else begin
         hi = '0;
         lo = {src_i[HALF_W-1:0], dst_i[HALF_W-1:0]};
      end
      word_o = left ? {1'b0, hi, lo} : {hi, lo, 1'b0};
   end
endmodule

// File: rtl/dfs_funnel_core.sv
// Barrel shift of the funnel word. STAGED=1 builds log2 mux stages;
// STAGED=0 leaves the shifter structure to the operator.
module dfs_funnel_core #(
   parameter int WORD_W = 65,
   parameter int SH_W   = 5,
   parameter bit STAGED = 1'b1
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [SH_W-1:0]   amt_i,
   input  logic              left_i,
   output logic [WORD_W-1:0] word_o
);
   initial begin
      assert (SH_W >= 1 && (1 << SH_W) < WORD_W)
         else $fatal(1, "dfs_funnel_core: SH_W out of range");
   end

   generate
      if (STAGED) begin : g_staged
         logic [WORD_W-1:0] stage [SH_W+1];
         assign stage[0] = word_i;
         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            localparam int STEP = 1 << k;
            assign stage[k+1] = !amt_i[k] ? stage[k]
                              : left_i    ? (stage[k] << STEP)
                                          : (stage[k] >> STEP);
         end
         assign word_o = stage[SH_W];
      end else begin : g_flat
         assign word_o = left_i ? (word_i << amt_i) : (word_i >> amt_i);
      end
   endgenerate
endmodule

// File: rtl/dfs_out_reg.sv
module dfs_out_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  logic              keep_carry_i,
   input  logic [DATA_W-1:0] result_i,
   input  logic              carry_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o  <= 1'b0;
         result_o <= '0;
         carry_o  <= 1'b0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) begin
            result_o <= result_i;
            if (!keep_carry_i) carry_o <= carry_i;
         end
      end
   end

   // R2: an idle cycle leaves the result and carry registers untouched
   p_idle_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) && !$past(valid_i) |-> $stable(result_o) && $stable(carry_o));
endmodule

// File: rtl/dbl_funnel_shifter.sv
module dbl_funnel_shifter
   import dfs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit STAGED = 1'b1,
   localparam int HALF_W = DATA_W / 2,
   localparam int SH_W   = $clog2(DATA_W),
   localparam int WORD_W = 2 * DATA_W + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  logic              dir_i,
   input  logic              size_i,
   input  logic [SH_W-1:0]   count_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o
);
   initial begin
      assert (DATA_W >= 8 && (DATA_W & (DATA_W - 1)) == 0)
         else $fatal(1, "dbl_funnel_shifter: DATA_W must be a power of two >= 8");
   end

   logic [WORD_W-1:0] packed_w, shifted_w;
   logic [DATA_W-1:0] res_d;
   logic              cy_d;
   logic              left;

   assign left = (dir_i == DIR_LEFT);

   dfs_pack #(.DATA_W(DATA_W)) u_pack (
      .dir_i  (dir_i),
      .size_i (size_i),
      .dst_i  (dst_i),
      .src_i  (src_i),
      .word_o (packed_w)
   );

   dfs_funnel_core #(.WORD_W(WORD_W), .SH_W(SH_W), .STAGED(STAGED)) u_core (
      .word_i (packed_w),
      .amt_i  (count_i),
      .left_i (left),
      .word_o (shifted_w)
   );

   // Window extraction: the carry is the bit just beyond the window edge.
   always_comb begin
      res_d = '0;
      if (left) begin
         cy_d = shifted_w[2*DATA_W];
         if (size_i == SIZE_FULL) res_d = shifted_w[2*DATA_W-1:DATA_W];
         else res_d[HALF_W-1:0] = shifted_w[2*DATA_W-1:2*DATA_W-HALF_W];
      end else begin
         cy_d = shifted_w[0];
         if (size_i == SIZE_FULL) res_d = shifted_w[DATA_W:1];
         else res_d[HALF_W-1:0] = shifted_w[HALF_W:1];
      end
   end

   dfs_out_reg #(.DATA_W(DATA_W)) u_out (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .valid_i      (valid_i),
      .keep_carry_i (count_i == '0),
      .result_i     (res_d),
      .carry_i      (cy_d),
      .valid_o      (valid_o),
      .result_o     (result_o),
      .carry_o      (carry_o)
   );

   p_strobe_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (valid_o == $past(valid_i)));

   p_zero_carry_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) && $past(valid_i) && ($past(count_i) == '0)
      |-> (carry_o == $past(carry_o)));

   p_zero_full_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) && $past(valid_i) && ($past(count_i) == '0)
      && ($past(size_i) == SIZE_FULL) |-> (result_o == $past(dst_i)));

   p_half_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) && $past(valid_i) && ($past(size_i) == SIZE_HALF)
      |-> (result_o[DATA_W-1:HALF_W] == '0));

   p_reset_clear_r1: assert property (@(posedge clk_i)
      !rst_ni |-> !valid_o && (result_o == '0) && !carry_o);
endmodule

// File: tb/dbl_funnel_shifter_tb.sv
`timescale 1ns/1ps
module dbl_funnel_shifter_tb;
   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        valid_i = 1'b0;
   logic        dir_i = 1'b0;
   logic        size_i = 1'b1;
   logic [4:0]  count_i = '0;
   logic [31:0] dst_i = '0;
   logic [31:0] src_i = '0;
   logic        valid_o;
   logic [31:0] result_o;
   logic        carry_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [31:0] exp_res;
   logic        exp_cy;
   bit          cy_known = 1'b1;
   bit          res_known = 1'b1;

   always #2 clk = ~clk;

   dbl_funnel_shifter u_dut (
      .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .dir_i(dir_i),
      .size_i(size_i), .count_i(count_i), .dst_i(dst_i), .src_i(src_i),
      .valid_o(valid_o), .result_o(result_o), .carry_o(carry_o)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Reference model written from the requirement formulas.
   task automatic issue(bit right, bit full, int n, logic [31:0] d, logic [31:0] s);
      int w = full ? 32 : 16;
      longint unsigned mask = (64'd1 << w) - 1;
      longint unsigned dd = longint'(d) & mask;
      longint unsigned ss = longint'(s) & mask;
      valid_i = 1'b1; dir_i = right; size_i = full;
      count_i = 5'(n); dst_i = d; src_i = s;
      res_known = (n <= w);
      if (n == 0) begin
         exp_res = 32'(dd);
      end else if (n > w) begin
         cy_known = 1'b0;
      end else if (!right) begin
         exp_res = 32'(((dd << n) | (ss >> (w - n))) & mask);
         exp_cy  = 1'((dd >> (w - n)) & 1);
         cy_known = 1'b1;
      end else begin
         exp_res = 32'(((dd >> n) | (ss << (w - n))) & mask);
         exp_cy  = 1'((dd >> (n - 1)) & 1);
         cy_known = 1'b1;
      end
   endtask

   task automatic check_op(string req);
      chk({req, " valid"}, 32'(valid_o), 32'd1);
      if (res_known) chk({req, " result"}, result_o, exp_res);
      if (cy_known)  chk({req, " carry"}, 32'(carry_o), 32'(exp_cy));
   endtask

   task automatic run_op(string req, bit right, bit full, int n,
                         logic [31:0] d, logic [31:0] s);
      issue(right, full, n, d, s);
      @(negedge clk);
      valid_i = 1'b0;
      check_op(req);
   endtask

   task automatic t_reset();
      chk("R1 valid", 32'(valid_o), 32'd0);
      chk("R1 result", result_o, 32'd0);
      chk("R1 carry", 32'(carry_o), 32'd0);
      rst_ni = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R1 valid after release", 32'(valid_o), 32'd0);
   endtask

   task automatic t_left_full();
      run_op("R3 R5 left5", 1'b0, 1'b1, 5, 32'h1234_5678, 32'hF800_0000);
      run_op("R3 R5 left1", 1'b0, 1'b1, 1, 32'h8000_0001, 32'h7FFF_FFFF);
      run_op("R3 R5 left13", 1'b0, 1'b1, 13, 32'hDEAD_BEEF, 32'hCAFE_F00D);
      run_op("R9 left31", 1'b0, 1'b1, 31, 32'h0000_0003, 32'hAAAA_AAAA);
   endtask

   task automatic t_right_full();
      run_op("R4 R6 right8", 1'b1, 1'b1, 8, 32'h1234_5678, 32'h0000_00A5);
      run_op("R4 R6 right1", 1'b1, 1'b1, 1, 32'h0000_0001, 32'h0000_0000);
      run_op("R4 R6 right20", 1'b1, 1'b1, 20, 32'h0F0F_0F0F, 32'h1357_9BDF);
      run_op("R9 right31", 1'b1, 1'b1, 31, 32'hC000_0000, 32'h5555_5555);
   endtask

   task automatic t_half();
      run_op("R8 left4", 1'b0, 1'b0, 4, 32'hFFFF_1234, 32'hEEEE_ABCD);
      run_op("R8 right7", 1'b1, 1'b0, 7, 32'h9999_8421, 32'h7777_00FF);
      run_op("R8 left16", 1'b0, 1'b0, 16, 32'h0000_0001, 32'h1111_BEEF);
      run_op("R8 right16", 1'b1, 1'b0, 16, 32'h0000_8000, 32'h2222_C0DE);
      // Undefined count: only the upper half and strobe are judged.
      issue(1'b0, 1'b0, 20, 32'h1234_5678, 32'h9ABC_DEF0);
      @(negedge clk);
      valid_i = 1'b0;
      chk("R8 undefined count valid", 32'(valid_o), 32'd1);
      chk("R8 undefined count upper zero", {16'h0, result_o[31:16]}, 32'd0);
   endtask

   task automatic t_zero_b2b();
      // Carry 1 from a left shift, then zero count on the next strobe.
      issue(1'b0, 1'b1, 3, 32'h2000_0000, 32'h0);
      @(negedge clk);
      check_op("R5 setup carry1");
      issue(1'b1, 1'b1, 0, 32'h0BAD_F00D, 32'hFFFF_FFFF);
      @(negedge clk);
      check_op("R7 zero count keeps carry1");
      // Carry 0 from a right shift, then zero count in half mode.
      issue(1'b1, 1'b1, 4, 32'hFFFF_FFF7, 32'h0);
      @(negedge clk);
      check_op("R6 setup carry0");
      issue(1'b0, 1'b0, 0, 32'hABCD_5A5A, 32'h1234_5678);
      @(negedge clk);
      valid_i = 1'b0;
      check_op("R7 R8 zero count half keeps carry0");
   endtask

   task automatic t_idle_hold();
      logic [31:0] r_before = result_o;
      logic        c_before = carry_o;
      valid_i = 1'b0; dst_i = 32'h5A5A_5A5A; src_i = 32'hA5A5_A5A5;
      count_i = 5'd9; dir_i = 1'b1; size_i = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R2 idle valid low", 32'(valid_o), 32'd0);
      chk("R2 idle result held", result_o, r_before);
      chk("R2 idle carry held", 32'(carry_o), 32'(c_before));
   endtask

   initial begin
      @(negedge clk); @(negedge clk);
      t_reset();
      t_left_full();
      t_right_full();
      t_half();
      t_zero_b2b();
      t_idle_hold();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule